// File: doc/BRIEF.md
# Receive Mailbox Acceptance and Allocation

This block sits between a CAN bit engine and a bank of message mailboxes. When the engine delivers a complete frame, the block compares the frame's identifier against every mailbox's stored identifier. Each comparison applies that mailbox's own acceptance mask. The block then decides which single mailbox takes the frame. The search runs from the highest-numbered mailbox downward. A mailbox that still holds an unread message is either overwritten or passed over, according to its overwrite-protect bit. A remote frame that hits a transmit mailbox configured for automatic reply raises that mailbox's transmit request and does not store a message anywhere.

The block keeps one pending flag and one lost flag per mailbox. The CPU clears each flag by writing a 1 to it. Any set lost flag raises a summary interrupt flag. The block outputs a one-cycle store strobe together with the chosen mailbox index, so the data path can write the payload. Mailbox configuration is expected to stay stable while a frame is in flight.

Top module: `mbx_rx_alloc`

## Requirements
- R1: A data frame can only be stored in a mailbox that is enabled (`mbx_en_i[n]=1`) and set to receive (`mbx_rx_i[n]=1`). A mailbox that is disabled, or set to transmit (`mbx_rx_i[n]=0`), never takes a data frame.
- R2: When several eligible mailboxes match, the one with the highest index is chosen. The index is reported on `store_idx_o` while `store_o` is high.
- R3: When `mbx_ame_i[n]=1`, a 1 in `mbx_mask_i[n]` bit b makes identifier bit b a don't-care. A 0 in that bit requires received bit b to equal stored bit b.
- R4: When `mbx_ame_i[n]=0`, the mask is ignored. The received IDE must equal `mbx_ide_i[n]`, and every compared identifier bit must be equal.
- R5: For a standard frame (IDE=0), only identifier bits 28..18 are compared, and bits 17..0 are ignored. For an extended frame, all 29 bits are compared. When `mbx_ame_i[n]=1` and `mbx_ide_dc_i[n]=1`, the mailbox's IDE bit is ignored and the frame's IDE sets the compare length.
- R6: If the chosen mailbox is already pending and `mbx_opc_i[n]=0`, it is overwritten. `store_o` pulses for that index, and its lost flag is set in the same cycle.
- R7: A matching mailbox that is pending with `mbx_opc_i[n]=1` is skipped, and its lost flag is left unchanged. The search continues with lower-numbered mailboxes.
- R8: A remote frame (RTR=1) that matches an enabled transmit mailbox with `mbx_aam_i[n]=1` pulses `tx_req_set_o[n]` for one cycle. This pulse is one-hot, with no store. A matching transmit mailbox with `mbx_aam_i[n]=0` is skipped. A remote frame that matches a receive mailbox is stored like a data frame.
- R9: Writing 1 to `pend_clr_i[n]` or `lost_clr_i[n]` clears the flag on the next edge. A hardware set and a CPU clear on the same edge leave the flag set.
- R10: `lost_irq_o` is high exactly when any bit of `lost_o` is high.
- R11: A frame sampled with `frame_valid_i=1` on rising edge k updates the flags and drives `store_o` or `tx_req_set_o` after edge k+2. These outputs are one-cycle pulses. A frame that matches no mailbox changes nothing.
- R12: Asynchronous reset clears all pending and lost flags and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Received frame strobe |
| frame_id_i | input | 29 | Received identifier (standard id in bits 28..18) |
| frame_ide_i | input | 1 | Received frame is extended |
| frame_rtr_i | input | 1 | Received frame is remote |
| mbx_en_i | input | NUM_MBX | Mailbox enable |
| mbx_rx_i | input | NUM_MBX | 1 = receive mailbox, 0 = transmit mailbox |
| mbx_id_i | input | NUM_MBX x 29 | Stored identifiers |
| mbx_ide_i | input | NUM_MBX | Stored IDE bits |
| mbx_ame_i | input | NUM_MBX | Acceptance-mask enable |
| mbx_ide_dc_i | input | NUM_MBX | IDE don't-care (effective with mask enable) |
| mbx_mask_i | input | NUM_MBX x 29 | Local acceptance masks, 1 = don't care |
| mbx_aam_i | input | NUM_MBX | Automatic reply to remote frames |
| mbx_opc_i | input | NUM_MBX | Overwrite protection |
| pend_clr_i | input | NUM_MBX | Write-1-to-clear for pending flags |
| lost_clr_i | input | NUM_MBX | Write-1-to-clear for lost flags |
| store_o | output | 1 | Store strobe |
| store_idx_o | output | IDX_W | Mailbox chosen for storing |
| tx_req_set_o | output | NUM_MBX | One-hot transmit-request set pulse |
| pend_o | output | NUM_MBX | Pending flags |
| lost_o | output | NUM_MBX | Lost flags |
| lost_irq_o | output | 1 | Any lost flag set |

## Verification
Suppose a wrong hit vector or a wrong priority choice occurs. It shows two edges after the frame strobe, as a wrong `store_idx_o` or a missing or extra `store_o`. In the same cycle, a pending bit appears in the wrong place. A corrupt pending flag stays hidden until the next frame for that mailbox. That frame then shows a wrong skip or overwrite decision and a wrong lost bit. The bench therefore replays each frame against a reference model and compares every output on every clock. This catches a divergence in the cycle it first reaches a port.

// File: rtl/mbx_acc_pkg.sv
package mbx_acc_pkg;
  localparam int unsigned ID_W  = 29;
  localparam int unsigned STD_W = 11;
  localparam int unsigned EXT_W = ID_W - STD_W;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
  } frame_t;
endpackage

// File: rtl/mbx_id_match.sv
module mbx_id_match
  import mbx_acc_pkg::*;
(
  input  logic [ID_W-1:0] frm_id_i,
  input  logic            frm_ide_i,
  input  logic [ID_W-1:0] mbx_id_i,
  input  logic            mbx_ide_i,
  input  logic            ame_i,
  input  logic            ide_dc_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            hit_o
);
  logic [ID_W-1:0] care;
  logic            ide_ok;

  always_comb begin
    care = ame_i ? ~mask_i : {ID_W{1'b1}};
    // standard frames carry only the upper field
    if (!frm_ide_i) care[EXT_W-1:0] = '0;
    ide_ok = (ame_i && ide_dc_i) || (frm_ide_i == mbx_ide_i);
    hit_o  = ide_ok && (((frm_id_i ^ mbx_id_i) & care) == '0);
  end
endmodule

// File: rtl/mbx_pick.sv
module mbx_pick #(
  parameter  int unsigned NUM_MBX = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               vld_i,
  input  logic               rtr_i,
  input  logic [NUM_MBX-1:0] hit_i,
  input  logic [NUM_MBX-1:0] en_i,
  input  logic [NUM_MBX-1:0] rx_i,
  input  logic [NUM_MBX-1:0] aam_i,
  input  logic [NUM_MBX-1:0] opc_i,
  input  logic [NUM_MBX-1:0] pend_i,
  output logic               take_o,
  output logic               ans_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_MBX-1:0] cand;

  // protected pending mailboxes and non-replying transmit mailboxes drop out
  always_comb begin
    for (int i = 0; i < NUM_MBX; i++) begin
      cand[i] = vld_i && hit_i[i] && en_i[i] &&
                (rx_i[i] ? (!pend_i[i] || !opc_i[i]) : (rtr_i && aam_i[i]));
    end
  end

  // ascending scan, so the highest candidate is the last one written
  always_comb begin
    take_o = 1'b0;
    idx_o  = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (cand[i]) begin
        take_o = 1'b1;
        idx_o  = IDX_W'(i);
      end
    end
    ans_o = take_o && !rx_i[idx_o];
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int unsigned NUM_MBX = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MBX-1:0] set_i,
  input  logic [NUM_MBX-1:0] pend_clr_i,
  input  logic [NUM_MBX-1:0] lost_clr_i,
  output logic [NUM_MBX-1:0] pend_o,
  output logic [NUM_MBX-1:0] lost_o
);
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[i] <= 1'b0;
        lost_o[i] <= 1'b0;
      end else begin
        // set beats clear
        pend_o[i] <= (pend_o[i] && !pend_clr_i[i]) || set_i[i];
        lost_o[i] <= (lost_o[i] && !lost_clr_i[i]) || (set_i[i] && pend_o[i]);
      end
    end
  end
endmodule

// File: rtl/mbx_rx_alloc.sv
module mbx_rx_alloc
  import mbx_acc_pkg::*;
#(
  parameter  int unsigned NUM_MBX = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_MBX)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_valid_i,
  input  logic [ID_W-1:0]               frame_id_i,
  input  logic                          frame_ide_i,
  input  logic                          frame_rtr_i,
  input  logic [NUM_MBX-1:0]            mbx_en_i,
  input  logic [NUM_MBX-1:0]            mbx_rx_i,
  input  logic [NUM_MBX-1:0][ID_W-1:0]  mbx_id_i,
  input  logic [NUM_MBX-1:0]            mbx_ide_i,
  input  logic [NUM_MBX-1:0]            mbx_ame_i,
  input  logic [NUM_MBX-1:0]            mbx_ide_dc_i,
  input  logic [NUM_MBX-1:0][ID_W-1:0]  mbx_mask_i,
  input  logic [NUM_MBX-1:0]            mbx_aam_i,
  input  logic [NUM_MBX-1:0]            mbx_opc_i,
  input  logic [NUM_MBX-1:0]            pend_clr_i,
  input  logic [NUM_MBX-1:0]            lost_clr_i,
  output logic                          store_o,
  output logic [IDX_W-1:0]              store_idx_o,
  output logic [NUM_MBX-1:0]            tx_req_set_o,
  output logic [NUM_MBX-1:0]            pend_o,
  output logic [NUM_MBX-1:0]            lost_o,
  output logic                          lost_irq_o
);
  localparam logic [NUM_MBX-1:0] ONE = NUM_MBX'(1);

  frame_t             frm_q;
  logic               vld1_q, vld2_q, rtr2_q;
  logic [NUM_MBX-1:0] hit, hit_q;
  logic               take, ans;
  logic [IDX_W-1:0]   idx;
  logic [NUM_MBX-1:0] sel_vec, store_set;

  // stage 1: capture frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      vld1_q <= frame_valid_i;
      if (frame_valid_i) frm_q <= '{id: frame_id_i, ide: frame_ide_i, rtr: frame_rtr_i};
    end
  end

  // stage 2: per-mailbox compare
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_cmp
    mbx_id_match u_match (
      .frm_id_i  (frm_q.id),
      .frm_ide_i (frm_q.ide),
      .mbx_id_i  (mbx_id_i[i]),
      .mbx_ide_i (mbx_ide_i[i]),
      .ame_i     (mbx_ame_i[i]),
      .ide_dc_i  (mbx_ide_dc_i[i]),
      .mask_i    (mbx_mask_i[i]),
      .hit_o     (hit[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld2_q <= 1'b0;
      rtr2_q <= 1'b0;
      hit_q  <= '0;
    end else begin
      vld2_q <= vld1_q;
      rtr2_q <= frm_q.rtr;
      hit_q  <= vld1_q ? hit : '0;
    end
  end

  // stage 3: priority pick against live pending state
  mbx_pick #(.NUM_MBX(NUM_MBX)) u_pick (
    .vld_i  (vld2_q),
    .rtr_i  (rtr2_q),
    .hit_i  (hit_q),
    .en_i   (mbx_en_i),
    .rx_i   (mbx_rx_i),
    .aam_i  (mbx_aam_i),
    .opc_i  (mbx_opc_i),
    .pend_i (pend_o),
    .take_o (take),
    .ans_o  (ans),
    .idx_o  (idx)
  );

  assign sel_vec   = ONE << idx;
  assign store_set = (take && !ans) ? sel_vec : '0;

  mbx_flags #(.NUM_MBX(NUM_MBX)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (store_set),
    .pend_clr_i (pend_clr_i),
    .lost_clr_i (lost_clr_i),
    .pend_o     (pend_o),
    .lost_o     (lost_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o      <= 1'b0;
      store_idx_o  <= '0;
      tx_req_set_o <= '0;
    end else begin
      store_o      <= take && !ans;
      if (take) store_idx_o <= idx;
      tx_req_set_o <= (take && ans) ? sel_vec : '0;
    end
  end

  assign lost_irq_o = |lost_o;
endmodule

// File: rtl/mbx_rx_alloc_chk.sv
module mbx_rx_alloc_chk #(
  parameter  int unsigned NUM_MBX = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_MBX)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_valid_i,
  input logic [NUM_MBX-1:0] mbx_en_i,
  input logic [NUM_MBX-1:0] mbx_rx_i,
  input logic               store_o,
  input logic [IDX_W-1:0]   store_idx_o,
  input logic [NUM_MBX-1:0] tx_req_set_o,
  input logic [NUM_MBX-1:0] pend_o,
  input logic [NUM_MBX-1:0] lost_o,
  input logic               lost_irq_o
);
  p_store_rx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> (mbx_en_i[store_idx_o] && mbx_rx_i[store_idx_o]));

  p_pend_on_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> pend_o[store_idx_o]);

  p_lost_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_o |-> ((lost_o & ~$past(lost_o)) == '0));

  p_pend_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_o |-> ((pend_o & ~$past(pend_o)) == '0));

  p_tx_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_req_set_o));

  p_tx_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_req_set_o) |-> !store_o);

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_irq_o == (|lost_o));

  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || (|tx_req_set_o)) |-> $past(frame_valid_i, 3));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r12: assert (pend_o == '0 && lost_o == '0 && !store_o && tx_req_set_o == '0);
    end
  end
endmodule

bind mbx_rx_alloc mbx_rx_alloc_chk #(.NUM_MBX(NUM_MBX)) u_chk (.*);

// File: tb/sim_mbx_rx_alloc.sv
module sim_mbx_rx_alloc;
  localparam int N = 32;
  localparam int W = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic fv, fide, frtr;
  logic [W-1:0] fid;
  logic [N-1:0] en, rx, ide, ame, dc, aam, opc, pclr, lclr;
  logic [N-1:0][W-1:0] mid, mmask;
  logic store, irq;
  logic [4:0] sidx;
  logic [N-1:0] txs, pend, lost;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;

  mbx_rx_alloc #(.NUM_MBX(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .frame_id_i(fid),
    .frame_ide_i(fide), .frame_rtr_i(frtr), .mbx_en_i(en), .mbx_rx_i(rx),
    .mbx_id_i(mid), .mbx_ide_i(ide), .mbx_ame_i(ame), .mbx_ide_dc_i(dc),
    .mbx_mask_i(mmask), .mbx_aam_i(aam), .mbx_opc_i(opc), .pend_clr_i(pclr),
    .lost_clr_i(lclr), .store_o(store), .store_idx_o(sidx), .tx_req_set_o(txs),
    .pend_o(pend), .lost_o(lost), .lost_irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic [W-1:0] id; bit ide; bit rtr; longint due; } fr_t;
  fr_t q[$];
  longint cyc = 0;
  bit [N-1:0] m_pend = '0, m_lost = '0, e_tx = '0, sp, sl;
  bit e_store = 0;
  int e_idx = 0;
  fr_t f;

  function automatic bit m_hit(int i, logic [W-1:0] id, bit fi);
    if (!(ame[i] && dc[i]) && (fi != ide[i])) return 0;
    for (int b = 0; b < W; b++) begin
      if (!fi && b < 18) continue;
      if (ame[i] && mmask[i][b]) continue;
      if (id[b] != mid[i][b]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_lost = '0; e_tx = '0; e_store = 0; q.delete();
    end else begin
      cyc++;
      e_store = 0; e_tx = '0; sp = '0; sl = '0;
      if (q.size() > 0 && q[0].due == cyc) begin
        bit done;
        f = q.pop_front();
        done = 0;
        for (int i = N - 1; i >= 0; i--) begin
          if (!done && en[i] && m_hit(i, f.id, f.ide)) begin
            if (!rx[i]) begin
              if (f.rtr && aam[i]) begin e_tx[i] = 1; done = 1; end
            end else if (!(m_pend[i] && opc[i])) begin
              e_store = 1; e_idx = i; sp[i] = 1;
              if (m_pend[i]) sl[i] = 1;
              done = 1;
            end
          end
        end
      end
      m_pend = (m_pend & ~pclr) | sp;
      m_lost = (m_lost & ~lclr) | sl;
      if (fv) q.push_back('{fid, fide, frtr, cyc + 2});
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(store === e_store, "R2 store strobe vs model", 64'(store), 64'(e_store));
      if (e_store) chk(sidx == 5'(e_idx), "R2 store index vs model", 64'(sidx), 64'(e_idx));
      chk(txs === e_tx, "R8 tx request vs model", 64'(txs), 64'(e_tx));
      chk(pend === m_pend, "R9 pending vs model", 64'(pend), 64'(m_pend));
      chk(lost === m_lost, "R6 lost vs model", 64'(lost), 64'(m_lost));
      chk(irq === (|m_lost), "R10 irq vs model", 64'(irq), 64'(|m_lost));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [W-1:0] id, input bit e, input bit r);
    @(negedge clk); fv = 1; fid = id; fide = e; frtr = r;
    @(negedge clk); fv = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic w1c(input logic [N-1:0] p, input logic [N-1:0] l);
    @(negedge clk); pclr = p; lclr = l;
    @(negedge clk); pclr = '0; lclr = '0;
  endtask

  task automatic exp_store(input string tag, input bit s, input int i);
    chk(store === s, tag, 64'(store), 64'(s));
    if (s) chk(sidx == 5'(i), tag, 64'(sidx), 64'(i));
  endtask

  localparam logic [W-1:0] ID_A = 29'h0ABC1234;
  localparam logic [W-1:0] ID_B = 29'h12345678;
  localparam logic [W-1:0] ID_C = 29'h0F0F0F00;
  localparam logic [W-1:0] ID_D = 29'h1AB40155;
  localparam logic [W-1:0] ID_E = 29'h05551111;
  localparam logic [W-1:0] ID_F = 29'h00000777;

  initial begin
    fv = 0; fid = '0; fide = 0; frtr = 0;
    en = '0; rx = '0; ide = '0; ame = '0; dc = '0; aam = '0; opc = '0;
    pclr = '0; lclr = '0; mid = '0; mmask = '0;
    repeat (3) @(negedge clk);
    chk(pend == '0 && lost == '0 && !store && !irq && txs == '0, "R12 reset state",
        64'(pend | lost), 64'h0);
    rst_n = 1; cmp_on = 1;

    // R1: transmit and disabled mailboxes ignore data frames
    mid[5] = ID_A; en[5] = 1; rx[5] = 0; ide[5] = 1;
    mid[7] = ID_A; en[7] = 0; rx[7] = 1; ide[7] = 1;
    send(ID_A, 1, 0);
    exp_store("R1 no eligible mailbox", 0, 0);
    chk(pend == '0, "R1 no flag change", 64'(pend), 64'h0);
    mid[3] = ID_A; en[3] = 1; rx[3] = 1; ide[3] = 1;
    send(ID_A, 1, 0);
    exp_store("R1 enabled receive mailbox", 1, 3);

    // R2: highest index wins
    mid[10] = ID_B; en[10] = 1; rx[10] = 1; ide[10] = 1;
    mid[20] = ID_B; en[20] = 1; rx[20] = 1; ide[20] = 1;
    send(ID_B, 1, 0);
    exp_store("R2 highest match", 1, 20);

    // R7: protected pending mailbox skipped
    opc[20] = 1;
    send(ID_B, 1, 0);
    exp_store("R7 skip protected", 1, 10);
    chk(lost == '0, "R7 lost untouched", 64'(lost), 64'h0);
    // R6: unprotected pending mailbox overwritten
    send(ID_B, 1, 0);
    exp_store("R6 overwrite", 1, 10);
    chk(lost == (32'h1 << 10), "R6 lost set", 64'(lost), 64'(32'h1 << 10));
    chk(irq === 1'b1, "R10 irq high", 64'(irq), 64'h1);

    // R9: clear, then set wins over clear
    w1c(32'h1 << 3, '0);
    chk(pend[3] == 1'b0, "R9 pending cleared", 64'(pend[3]), 64'h0);
    @(negedge clk); fv = 1; fid = ID_A; fide = 1; frtr = 0;
    @(negedge clk); fv = 0;
    @(negedge clk); pclr = 32'h1 << 3;
    @(negedge clk); pclr = '0;
    chk(pend[3] == 1'b1, "R9 set wins over clear", 64'(pend[3]), 64'h1);
    w1c('0, 32'h1 << 10);
    chk(lost == '0, "R9 lost cleared", 64'(lost), 64'h0);
    chk(irq === 1'b0, "R10 irq low", 64'(irq), 64'h0);

    // R3: local mask
    mid[12] = ID_C; en[12] = 1; rx[12] = 1; ide[12] = 1; ame[12] = 1; mmask[12] = 29'hF;
    send(ID_C ^ 29'h5, 1, 0);
    exp_store("R3 masked bits ignored", 1, 12);
    send(ID_C ^ 29'h10, 1, 0);
    exp_store("R3 unmasked bit must match", 0, 0);

    // R4: mask disabled means exact match, IDE must match
    ame[12] = 0;
    w1c(32'h1 << 12, '0);
    send(ID_C ^ 29'h5, 1, 0);
    exp_store("R4 exact match required", 0, 0);
    send(ID_C, 0, 0);
    exp_store("R4 IDE mismatch rejected", 0, 0);
    send(ID_C, 1, 0);
    exp_store("R4 exact match stored", 1, 12);

    // R5: standard frame compares bits 28..18 only; IDE don't-care
    mid[14] = ID_D; en[14] = 1; rx[14] = 1; ide[14] = 0;
    send((ID_D & ~29'h3FFFF) | 29'h2AAAA, 0, 0);
    exp_store("R5 standard low bits ignored", 1, 14);
    mid[15] = ID_E; en[15] = 1; rx[15] = 1; ide[15] = 1; ame[15] = 1; dc[15] = 1;
    send((ID_E & ~29'h3FFFF) | 29'h00123, 0, 0);
    exp_store("R5 IDE don't-care standard", 1, 15);

    // R8: auto answer for remote frames
    mid[26] = ID_F; en[26] = 1; rx[26] = 0; ide[26] = 1; aam[26] = 0;
    mid[25] = ID_F; en[25] = 1; rx[25] = 0; ide[25] = 1; aam[25] = 1;
    mid[2]  = ID_F; en[2]  = 1; rx[2]  = 1; ide[2]  = 1;
    send(ID_F, 1, 1);
    exp_store("R8 answer does not store", 0, 0);
    chk(txs == (32'h1 << 25), "R8 tx request pulse", 64'(txs), 64'(32'h1 << 25));
    @(negedge clk);
    chk(txs == '0, "R11 tx request one cycle", 64'(txs), 64'h0);
    aam[25] = 0;
    send(ID_F, 1, 1);
    exp_store("R8 no reply falls to receive mailbox", 1, 2);
    chk(txs == '0, "R8 no tx request", 64'(txs), 64'h0);

    // R11: latency
    @(negedge clk); fv = 1; fid = ID_A; fide = 1; frtr = 0;
    @(negedge clk); fv = 0;
    @(negedge clk); chk(store === 1'b0, "R11 not before second edge", 64'(store), 64'h0);
    @(negedge clk); exp_store("R11 strobe after second edge", 1, 3);
    @(negedge clk); chk(store === 1'b0, "R11 single-cycle strobe", 64'(store), 64'h0);

    // random traffic against the model
    w1c('1, '1);
    for (int i = 0; i < N; i++) begin
      en[i] = ($urandom % 4) != 0;
      rx[i] = ($urandom % 4) != 0;
      ide[i] = $urandom % 2;
      ame[i] = $urandom % 2;
      dc[i] = $urandom % 2;
      aam[i] = $urandom % 2;
      opc[i] = $urandom % 2;
      mid[i] = (i % 2) ? ID_B : ID_C;
      if (i % 5 == 0) mid[i] = ID_E;
      mmask[i] = W'($urandom) & 29'h0C000F0F;
    end
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      fv = ($urandom % 2) != 0;
      case ($urandom % 3)
        0: fid = ID_B;
        1: fid = ID_C;
        default: fid = ID_E;
      endcase
      fid = fid ^ (W'($urandom) & 29'h04000303);
      fide = ($urandom % 4) != 0;
      frtr = ($urandom % 5) == 0;
      pclr = (($urandom % 8) == 0) ? N'($urandom) : '0;
      lclr = (($urandom % 8) == 0) ? N'($urandom) : '0;
    end
    @(negedge clk); fv = 0; pclr = '0; lclr = '0;
    repeat (4) @(negedge clk);

    // R12: reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk(pend == '0 && lost == '0 && !store, "R12 reset clears flags", 64'(pend | lost), 64'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule